// File: doc/BRIEF.md
# Speculative Branch History Queue

This block keeps an age-ordered list of the branch predictions that are still in flight for one hardware thread. Fetch inserts a record at the young end for every predicted branch. Each record carries a sequence number, the branch address, the predicted direction, an opaque handle into the direction predictor, a thread tag, call/return markers, return-stack bookkeeping (whether the stack was consulted or pushed, plus the stack index and target saved at prediction time) and a flag that marks a record already corrected by a mispredict. A multi-threaded core places one instance per thread.

Three operations work on the list through a single request port. A commit drains records from the old end and produces direction-training or retire-squashed events. A squash discards records from the young end and produces return-stack repair commands (restore or pop). A mispredict first performs a squash above the offending branch, then corrects that branch's record in place: it trains the predictor with the real outcome, updates the target buffer when the branch was taken, and repairs the return stack. The predictor tables, target buffer and return stack live outside; this block only drives their control signals.

A four-state machine handles the operations one record per cycle. ST_IDLE accepts a request (commit goes to ST_COMMIT; squash and mispredict go to ST_SQUASH; kind 3 stays in ST_IDLE). ST_COMMIT stays while the oldest record qualifies and returns to ST_IDLE otherwise. ST_SQUASH stays while the youngest record qualifies, then moves to ST_FIX for a mispredict or ST_IDLE for a plain squash. ST_FIX spends one cycle on the in-place correction and returns to ST_IDLE.

Top module: `branch_hist_queue`

## Requirements
- R1: After reset the queue is empty, `op_ready` and `pred_ready` are 1, `full` is 0, and no event output is valid.
- R2: A record is inserted at the young end when `pred_valid` and `pred_ready` are both 1; `pred_ready` is 0 while the queue holds DEPTH records or an operation is in progress, and an insert offered then is dropped.
- R3: A commit (`op_kind` 0) removes records from the old end, one per cycle, oldest first, while the oldest sequence number is less than or equal to `op_seq`; a removed record whose corrected flag is clear raises `upd_valid` with its address, predicted direction, handle and thread, and `upd_corrective` 0.
- R4: A committed record whose corrected flag is set raises `retsq_valid` with its handle instead of `upd_valid`.
- R5: A squash (`op_kind` 1) removes records from the young end, one per cycle, youngest first, while the youngest sequence number is greater than `op_seq`.
- R6: Each record removed by a squash with stack-used set raises `rasr_valid` with its saved index and target; with stack-used clear but both call and stack-pushed set it raises `raspop_valid`; otherwise it raises nothing.
- R7: A mispredict (`op_kind` 2) first squashes as in R5 and R6; then, if the youngest remaining record carries `op_seq`, it raises `upd_valid` with `upd_taken` = `op_taken`, `upd_corrective` 1, and sets that record's corrected flag.
- R8: In that correction with `op_taken` 1, `tgt_valid` is raised with the record's address and `op_target`, and a return whose stack-used bit was clear gets it set.
- R9: In that correction with `op_taken` 0, a record with stack-used set raises `rasr_valid` and has stack-used cleared; otherwise a call with stack-pushed set raises `raspop_valid` and has stack-pushed cleared.
- R10: A mispredict that finds the queue empty, or whose youngest remaining record carries another sequence number, makes no correction.
- R11: `op_ready` is 0 from the cycle after a request is accepted until the operation ends; events appear only while it is 0; `op_kind` 3 is ignored and leaves `op_ready` at 1.
- R12: Sequence numbers compare as unsigned SEQ_W-bit values, so a value with the top bit set is larger than one with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Insert a new prediction record |
| pred_ready | output | 1 | Insert is accepted this cycle |
| pred_seq | input | 16 | Sequence number of the new record |
| pred_pc | input | 32 | Branch address |
| pred_taken | input | 1 | Predicted direction |
| pred_hist | input | 8 | Opaque predictor history handle |
| pred_tid | input | 2 | Thread tag |
| pred_call | input | 1 | Branch is a call |
| pred_ret | input | 1 | Branch is a return |
| pred_used_ras | input | 1 | Target came from the return stack |
| pred_pushed_ras | input | 1 | Return stack was pushed |
| pred_ras_idx | input | 4 | Saved return-stack top index |
| pred_ras_tgt | input | 32 | Saved return-stack top target |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Block is idle and takes a request |
| op_kind | input | 2 | 0 commit, 1 squash, 2 mispredict, 3 none |
| op_seq | input | 16 | Sequence number bound of the operation |
| op_taken | input | 1 | Actual direction (mispredict) |
| op_target | input | 32 | Corrected target (mispredict) |
| upd_valid | output | 1 | Train the direction predictor |
| upd_pc | output | 32 | Address for training |
| upd_taken | output | 1 | Direction for training |
| upd_hist | output | 8 | Handle for training |
| upd_tid | output | 2 | Thread tag of the trained record |
| upd_corrective | output | 1 | Training comes from a mispredict |
| retsq_valid | output | 1 | Release the handle of a corrected record |
| retsq_hist | output | 8 | Handle to release |
| rasr_valid | output | 1 | Restore the return stack |
| rasr_idx | output | 4 | Index to restore |
| rasr_tgt | output | 32 | Target to restore |
| raspop_valid | output | 1 | Pop the return stack |
| tgt_valid | output | 1 | Write the target buffer |
| tgt_pc | output | 32 | Branch address for the target write |
| tgt_addr | output | 32 | Corrected target |
| full | output | 1 | Queue holds DEPTH records |

## Verification
The assertions take for granted that requests are offered only when `op_ready` is 1 and that sequence numbers of inserted records rise strictly from old to young without wrapping, so the bound comparisons are meaningful. The stimulus keeps a next-sequence counter that steps by one to three, waits for `op_ready` before each request, and picks commit, squash and mispredict bounds mostly from sequence numbers present in its own model, with some off-by-one values so that mismatched mispredicts and empty drains also occur. A final directed step uses values around the half-range of the sequence width to exercise the unsigned comparison.

// File: rtl/bhq_pkg.sv
package bhq_pkg;
    localparam int SEQ_W  = 16;
    localparam int PC_W   = 32;
    localparam int HIST_W = 8;
    localparam int TID_W  = 2;
    localparam int RIDX_W = 4;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   pc;
        logic              taken;
        logic [HIST_W-1:0] hist;
        logic [TID_W-1:0]  tid;
        logic              was_call;
        logic              was_ret;
        logic              used_ras;
        logic              pushed_ras;
        logic [RIDX_W-1:0] ras_idx;
        logic [PC_W-1:0]   ras_tgt;
        logic              squashed;
    } rec_t;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   pc;
        logic              taken;
        logic [HIST_W-1:0] hist;
        logic [TID_W-1:0]  tid;
        logic              squashed;
    } old_view_t;

    typedef enum logic [1:0] {
        OP_COMMIT  = 2'd0,
        OP_SQUASH  = 2'd1,
        OP_MISPRED = 2'd2,
        OP_NONE    = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_SQUASH,
        ST_FIX
    } st_e;
endpackage

// File: rtl/bhq_store.sv
module bhq_store
    import bhq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_en,
    input  rec_t      push_rec,
    input  logic      pop_old,
    input  logic      pop_young,
    input  logic      fix_en,
    input  rec_t      fix_rec,
    output old_view_t old_view,
    output rec_t      young_rec,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] head, tail, young_idx;
    logic [CNT_W-1:0] cnt;
    rec_t             old_rec;

    function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    assign young_idx = step_down(tail);
    assign young_rec = mem[young_idx];
    assign old_rec   = mem[head];
    assign empty     = (cnt == '0);
    assign full      = (cnt == FULL_CNT);

    always_comb begin
        old_view.seq      = old_rec.seq;
        old_view.pc       = old_rec.pc;
        old_view.taken    = old_rec.taken;
        old_view.hist     = old_rec.hist;
        old_view.tid      = old_rec.tid;
        old_view.squashed = old_rec.squashed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (push_en) begin
            mem[tail] <= push_rec;
            tail      <= step_up(tail);
            cnt       <= cnt + 1'b1;
        end else if (pop_old) begin
            head <= step_up(head);
            cnt  <= cnt - 1'b1;
        end else if (pop_young) begin
            tail <= young_idx;
            cnt  <= cnt - 1'b1;
        end else if (fix_en) begin
            mem[young_idx] <= fix_rec;
        end
    end
endmodule

// File: rtl/bhq_ctrl.sv
module bhq_ctrl
    import bhq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [SEQ_W-1:0]  op_seq,
    input  logic              op_taken,
    input  logic [PC_W-1:0]   op_target,
    input  old_view_t         old_view,
    input  rec_t              young_rec,
    input  logic              empty,
    output logic              op_ready,
    output logic              pop_old,
    output logic              pop_young,
    output logic              fix_en,
    output rec_t              fix_rec,
    output logic              upd_valid,
    output logic [PC_W-1:0]   upd_pc,
    output logic              upd_taken,
    output logic [HIST_W-1:0] upd_hist,
    output logic [TID_W-1:0]  upd_tid,
    output logic              upd_corrective,
    output logic              retsq_valid,
    output logic [HIST_W-1:0] retsq_hist,
    output logic              rasr_valid,
    output logic [RIDX_W-1:0] rasr_idx,
    output logic [PC_W-1:0]   rasr_tgt,
    output logic              raspop_valid,
    output logic              tgt_valid,
    output logic [PC_W-1:0]   tgt_pc,
    output logic [PC_W-1:0]   tgt_addr
);
    st_e              state, state_nx;
    logic [SEQ_W-1:0] bound;
    logic             is_misp;
    logic             act_taken;
    logic [PC_W-1:0]  act_tgt;
    logic             old_hit, young_hit, fix_hit;

    assign old_hit   = !empty && (old_view.seq <= bound);
    assign young_hit = !empty && (young_rec.seq > bound);
    assign fix_hit   = !empty && (young_rec.seq == bound);
    assign op_ready  = (state == ST_IDLE);
    assign rasr_idx  = young_rec.ras_idx;
    assign rasr_tgt  = young_rec.ras_tgt;
    assign retsq_hist = old_view.hist;
    assign tgt_pc    = young_rec.pc;
    assign tgt_addr  = act_tgt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bound     <= '0;
            is_misp   <= 1'b0;
            act_taken <= 1'b0;
            act_tgt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && op_valid) begin
                bound     <= op_seq;
                is_misp   <= (op_kind == OP_MISPRED);
                act_taken <= op_taken;
                act_tgt   <= op_target;
            end
        end
    end

    always_comb begin
        state_nx       = state;
        pop_old        = 1'b0;
        pop_young      = 1'b0;
        fix_en         = 1'b0;
        fix_rec        = young_rec;
        upd_valid      = 1'b0;
        upd_pc         = young_rec.pc;
        upd_taken      = act_taken;
        upd_hist       = young_rec.hist;
        upd_tid        = young_rec.tid;
        upd_corrective = 1'b0;
        retsq_valid    = 1'b0;
        rasr_valid     = 1'b0;
        raspop_valid   = 1'b0;
        tgt_valid      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (op_kind)
                        OP_COMMIT:  state_nx = ST_COMMIT;
                        OP_SQUASH:  state_nx = ST_SQUASH;
                        OP_MISPRED: state_nx = ST_SQUASH;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_COMMIT: begin
                if (old_hit) begin
                    pop_old = 1'b1;
                    if (old_view.squashed) begin
                        retsq_valid = 1'b1;
                    end else begin
                        upd_valid = 1'b1;
                        upd_pc    = old_view.pc;
                        upd_taken = old_view.taken;
                        upd_hist  = old_view.hist;
                        upd_tid   = old_view.tid;
                    end
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SQUASH: begin
                if (young_hit) begin
                    pop_young = 1'b1;
                    if (young_rec.used_ras) begin
                        rasr_valid = 1'b1;
                    end else if (young_rec.was_call && young_rec.pushed_ras) begin
                        raspop_valid = 1'b1;
                    end
                end else begin
                    state_nx = is_misp ? ST_FIX : ST_IDLE;
                end
            end
            ST_FIX: begin
                state_nx = ST_IDLE;
                if (fix_hit) begin
                    fix_en           = 1'b1;
                    upd_valid        = 1'b1;
                    upd_corrective   = 1'b1;
                    fix_rec.squashed = 1'b1;
                    if (act_taken) begin
                        tgt_valid = 1'b1;
                        if (young_rec.was_ret && !young_rec.used_ras) begin
                            fix_rec.used_ras = 1'b1;
                        end
                    end else if (young_rec.used_ras) begin
                        rasr_valid       = 1'b1;
                        fix_rec.used_ras = 1'b0;
                    end else if (young_rec.was_call && young_rec.pushed_ras) begin
                        raspop_valid       = 1'b1;
                        fix_rec.pushed_ras = 1'b0;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/branch_hist_queue.sv
module branch_hist_queue
    import bhq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    output logic              pred_ready,
    input  logic [SEQ_W-1:0]  pred_seq,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic              pred_taken,
    input  logic [HIST_W-1:0] pred_hist,
    input  logic [TID_W-1:0]  pred_tid,
    input  logic              pred_call,
    input  logic              pred_ret,
    input  logic              pred_used_ras,
    input  logic              pred_pushed_ras,
    input  logic [RIDX_W-1:0] pred_ras_idx,
    input  logic [PC_W-1:0]   pred_ras_tgt,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [SEQ_W-1:0]  op_seq,
    input  logic              op_taken,
    input  logic [PC_W-1:0]   op_target,
    output logic              upd_valid,
    output logic [PC_W-1:0]   upd_pc,
    output logic              upd_taken,
    output logic [HIST_W-1:0] upd_hist,
    output logic [TID_W-1:0]  upd_tid,
    output logic              upd_corrective,
    output logic              retsq_valid,
    output logic [HIST_W-1:0] retsq_hist,
    output logic              rasr_valid,
    output logic [RIDX_W-1:0] rasr_idx,
    output logic [PC_W-1:0]   rasr_tgt,
    output logic              raspop_valid,
    output logic              tgt_valid,
    output logic [PC_W-1:0]   tgt_pc,
    output logic [PC_W-1:0]   tgt_addr,
    output logic              full
);
    rec_t      new_rec, young_rec, fix_rec;
    old_view_t old_view;
    logic      empty, push_en, pop_old, pop_young, fix_en;

    always_comb begin
        new_rec.seq        = pred_seq;
        new_rec.pc         = pred_pc;
        new_rec.taken      = pred_taken;
        new_rec.hist       = pred_hist;
        new_rec.tid        = pred_tid;
        new_rec.was_call   = pred_call;
        new_rec.was_ret    = pred_ret;
        new_rec.used_ras   = pred_used_ras;
        new_rec.pushed_ras = pred_pushed_ras;
        new_rec.ras_idx    = pred_ras_idx;
        new_rec.ras_tgt    = pred_ras_tgt;
        new_rec.squashed   = 1'b0;
    end

    assign pred_ready = op_ready && !full;
    assign push_en    = pred_valid && pred_ready;

    bhq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_rec  (new_rec),
        .pop_old   (pop_old),
        .pop_young (pop_young),
        .fix_en    (fix_en),
        .fix_rec   (fix_rec),
        .old_view  (old_view),
        .young_rec (young_rec),
        .empty     (empty),
        .full      (full)
    );

    bhq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_kind        (op_kind),
        .op_seq         (op_seq),
        .op_taken       (op_taken),
        .op_target      (op_target),
        .old_view       (old_view),
        .young_rec      (young_rec),
        .empty          (empty),
        .op_ready       (op_ready),
        .pop_old        (pop_old),
        .pop_young      (pop_young),
        .fix_en         (fix_en),
        .fix_rec        (fix_rec),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_hist       (upd_hist),
        .upd_tid        (upd_tid),
        .upd_corrective (upd_corrective),
        .retsq_valid    (retsq_valid),
        .retsq_hist     (retsq_hist),
        .rasr_valid     (rasr_valid),
        .rasr_idx       (rasr_idx),
        .rasr_tgt       (rasr_tgt),
        .raspop_valid   (raspop_valid),
        .tgt_valid      (tgt_valid),
        .tgt_pc         (tgt_pc),
        .tgt_addr       (tgt_addr)
    );
endmodule

// File: rtl/bhq_chk.sv
module bhq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       full,
    input logic       pred_ready,
    input logic       op_valid,
    input logic       op_ready,
    input logic [1:0] op_kind,
    input logic       upd_valid,
    input logic       upd_corrective,
    input logic       retsq_valid,
    input logic       rasr_valid,
    input logic       raspop_valid,
    input logic       tgt_valid
);
    // R2
    full_blocks_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !pred_ready);

    // R4
    train_or_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && retsq_valid));

    // R6
    restore_or_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rasr_valid && raspop_valid));

    // R8
    target_with_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (upd_valid && upd_corrective));

    // R11
    events_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid || retsq_valid || rasr_valid || raspop_valid || tgt_valid) |-> !op_ready);

    // R11
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind != 2'd3) |=> !op_ready);

    // R11
    none_kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == 2'd3) |=> op_ready);
endmodule

bind branch_hist_queue bhq_chk u_chk (.*);

// File: tb/branch_hist_queue_test.sv
module branch_hist_queue_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    typedef logic [99:0] ev_t;
    typedef struct {
        logic [15:0] seq;
        logic [31:0] pc;
        logic        taken;
        logic [7:0]  hist;
        logic [1:0]  tid;
        logic        call;
        logic        ret;
        logic        used;
        logic        pushed;
        logic [3:0]  idx;
        logic [31:0] rtgt;
        logic        sq;
    } m_rec_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pred_valid = 0, pred_taken = 0, pred_call = 0, pred_ret = 0;
    logic pred_used_ras = 0, pred_pushed_ras = 0;
    logic [15:0] pred_seq = 0;
    logic [31:0] pred_pc = 0, pred_ras_tgt = 0;
    logic [7:0]  pred_hist = 0;
    logic [1:0]  pred_tid = 0;
    logic [3:0]  pred_ras_idx = 0;
    logic op_valid = 0, op_taken = 0;
    logic [1:0]  op_kind = 0;
    logic [15:0] op_seq = 0;
    logic [31:0] op_target = 0;
    logic pred_ready, op_ready, upd_valid, upd_taken, upd_corrective;
    logic retsq_valid, rasr_valid, raspop_valid, tgt_valid, full;
    logic [31:0] upd_pc, rasr_tgt, tgt_pc, tgt_addr;
    logic [7:0]  upd_hist, retsq_hist;
    logic [1:0]  upd_tid;
    logic [3:0]  rasr_idx;

    int checks = 0, fails = 0, next_seq = 10;
    m_rec_t model[$];
    ev_t exp_q[$], obs_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_hist_queue #(.DEPTH(DEPTH)) uut (.*);

    function automatic ev_t ev(input int k, input logic [31:0] a, input logic [31:0] b,
                               input logic [31:0] c);
        return {k[3:0], a, b, c};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic void model_squash(input logic [15:0] lim);
        while (model.size() > 0 && model[model.size()-1].seq > lim) begin
            m_rec_t r = model.pop_back();
            if (r.used) exp_q.push_back(ev(3, {28'b0, r.idx}, r.rtgt, 0));
            else if (r.call && r.pushed) exp_q.push_back(ev(4, 0, 0, 0));
        end
    endfunction

    function automatic void model_commit(input logic [15:0] lim);
        while (model.size() > 0 && model[0].seq <= lim) begin
            m_rec_t r = model.pop_front();
            if (r.sq) exp_q.push_back(ev(2, 0, 0, {24'b0, r.hist}));
            else exp_q.push_back(ev(1, r.pc, {31'b0, r.taken}, {22'b0, r.tid, r.hist}));
        end
    endfunction

    function automatic void model_fix(input logic [15:0] lim, input logic tk,
                                      input logic [31:0] tg);
        model_squash(lim);
        if (model.size() > 0 && model[model.size()-1].seq == lim) begin
            m_rec_t r = model[model.size()-1];
            exp_q.push_back(ev(1, r.pc, {30'b0, 1'b1, tk}, {22'b0, r.tid, r.hist}));
            if (tk) begin
                exp_q.push_back(ev(5, r.pc, tg, 0));
                if (r.ret && !r.used) r.used = 1'b1;
            end else if (r.used) begin
                exp_q.push_back(ev(3, {28'b0, r.idx}, r.rtgt, 0));
                r.used = 1'b0;
            end else if (r.call && r.pushed) begin
                exp_q.push_back(ev(4, 0, 0, 0));
                r.pushed = 1'b0;
            end
            r.sq = 1'b1;
            model[model.size()-1] = r;
        end
    endfunction

    task automatic collect();
        if (upd_valid) obs_q.push_back(ev(1, upd_pc, {30'b0, upd_corrective, upd_taken},
                                          {22'b0, upd_tid, upd_hist}));
        if (retsq_valid) obs_q.push_back(ev(2, 0, 0, {24'b0, retsq_hist}));
        if (rasr_valid) obs_q.push_back(ev(3, {28'b0, rasr_idx}, rasr_tgt, 0));
        if (raspop_valid) obs_q.push_back(ev(4, 0, 0, 0));
        if (tgt_valid) obs_q.push_back(ev(5, tgt_pc, tgt_addr, 0));
    endtask

    task automatic push_one(input m_rec_t r);
        logic exp_rdy;
        @(negedge clk);
        exp_rdy = (model.size() < DEPTH);
        chk("R2 pred_ready", {127'b0, pred_ready}, {127'b0, exp_rdy});
        pred_valid = 1; pred_seq = r.seq; pred_pc = r.pc; pred_taken = r.taken;
        pred_hist = r.hist; pred_tid = r.tid; pred_call = r.call; pred_ret = r.ret;
        pred_used_ras = r.used; pred_pushed_ras = r.pushed; pred_ras_idx = r.idx;
        pred_ras_tgt = r.rtgt;
        @(negedge clk);
        pred_valid = 0;
        if (exp_rdy) model.push_back(r);
    endtask

    function automatic m_rec_t rand_rec(input logic [15:0] s);
        m_rec_t r;
        r.seq = s; r.pc = $urandom; r.taken = 1'($urandom);
        r.hist = 8'($urandom); r.tid = 2'($urandom);
        r.call = ($urandom_range(0, 2) == 0); r.ret = ($urandom_range(0, 2) == 0);
        r.used = 1'($urandom); r.pushed = 1'($urandom);
        r.idx = 4'($urandom); r.rtgt = $urandom; r.sq = 1'b0;
        return r;
    endfunction

    task automatic run_op(input logic [1:0] k, input logic [15:0] s, input logic tk,
                          input logic [31:0] tg, input string tag);
        int guard;
        exp_q.delete(); obs_q.delete();
        case (k)
            2'd0: model_commit(s);
            2'd1: model_squash(s);
            2'd2: model_fix(s, tk, tg);
            default: ;
        endcase
        @(negedge clk);
        op_valid = 1; op_kind = k; op_seq = s; op_taken = tk; op_target = tg;
        @(negedge clk);
        op_valid = 0;
        if (k == 2'd3) chk({tag, " op_ready after kind 3"}, {127'b0, op_ready}, 128'd1);
        guard = 0;
        while (!op_ready && guard < 100) begin
            collect();
            @(negedge clk);
            guard++;
        end
        chk({tag, " event count"}, 128'(obs_q.size()), 128'(exp_q.size()));
        if (obs_q.size() == exp_q.size())
            foreach (exp_q[i]) chk({tag, " event"}, {28'b0, obs_q[i]}, {28'b0, exp_q[i]});
    endtask

    function automatic logic [15:0] pick_seq();
        return model[$urandom_range(0, model.size() - 1)].seq;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 op_ready", {127'b0, op_ready}, 128'd1);
        chk("R1 pred_ready", {127'b0, pred_ready}, 128'd1);
        chk("R1 full", {127'b0, full}, 128'd0);
        chk("R1 events", {123'b0, upd_valid, retsq_valid, rasr_valid, raspop_valid, tgt_valid}, 128'd0);

        // R10 mispredict on empty queue
        run_op(2'd2, 16'd5, 1'b1, 32'h1234, "R10 empty");
        // R11 kind 3 ignored
        run_op(2'd3, 16'd0, 1'b0, 32'h0, "R11 none");

        // R2 fill to full, extra insert dropped, drain with commit (R3)
        for (int i = 0; i < DEPTH + 1; i++) begin
            push_one(rand_rec(16'(next_seq)));
            next_seq += 1;
        end
        @(negedge clk);
        chk("R2 full", {127'b0, full}, 128'd1);
        run_op(2'd0, 16'hFFF0, 1'b0, 0, "R2/R3 drain");

        // R8 then R6: uncorrected return, taken fix, later squash restores
        begin
            m_rec_t r = rand_rec(16'(next_seq));
            r.ret = 1; r.call = 0; r.used = 0; r.pushed = 0;
            push_one(r);
            next_seq += 2;
            push_one(rand_rec(16'(next_seq)));
            run_op(2'd2, r.seq, 1'b1, 32'hCAFE0000, "R7/R8 taken fix");
            run_op(2'd1, r.seq - 16'd1, 1'b0, 0, "R8/R6 squash fixed");
            next_seq += 2;
        end
        // R9 not-taken fix of a pushed call, then commit shows release (R4)
        begin
            m_rec_t r = rand_rec(16'(next_seq));
            r.call = 1; r.used = 0; r.pushed = 1;
            push_one(r);
            run_op(2'd2, r.seq, 1'b0, 0, "R9 not-taken fix");
            run_op(2'd0, r.seq, 1'b0, 0, "R4 release");
            next_seq += 2;
        end

        // random mix
        for (int it = 0; it < 600; it++) begin
            int sel = $urandom_range(0, 9);
            if (sel < 5 || model.size() == 0) begin
                push_one(rand_rec(16'(next_seq)));
                if (model.size() > 0 && model[model.size()-1].seq == 16'(next_seq))
                    next_seq += $urandom_range(1, 3);
            end else if (sel < 7) begin
                run_op(2'd0, pick_seq() - 16'($urandom_range(0, 1)), 1'b0, 0, "R3/R4 commit");
            end else if (sel == 7) begin
                run_op(2'd1, pick_seq() - 16'($urandom_range(0, 1)), 1'b0, 0, "R5/R6 squash");
            end else if (sel == 8) begin
                run_op(2'd2, pick_seq() + 16'($urandom_range(0, 3) == 0), 1'($urandom),
                       $urandom, "R7/R8/R9 mispredict");
            end else begin
                run_op(2'd3, pick_seq(), 1'b0, 0, "R11 none");
            end
        end

        // R12 unsigned comparison across the top bit
        run_op(2'd1, 16'd0, 1'b0, 0, "R5 clear");
        push_one(rand_rec(16'h7FFF));
        push_one(rand_rec(16'h8001));
        run_op(2'd0, 16'h8000, 1'b0, 0, "R12 commit");
        run_op(2'd1, 16'h8000, 1'b0, 0, "R12 squash");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule